// File: doc/BRIEF.md
# Peripheral Soft-Reset and Clock-Gate Control Register

This block is the control word that software uses to reset one functional unit and to stop its clock. Two bits of the word matter. Bit 31 is the soft-reset request and bit 30 is the clock-gate request. Software can change them in three ways: with a plain write, through a set-only alias, or through a clear-only alias. The aliases let software change one bit without first reading the word.

The word drives two outputs. The first is a synchronous reset to the protected logic. The second is a clock-enable, which is the inverse of the gate bit. The hardware sequences itself. While the soft-reset bit reads 1 and the gate bit is not requested, an internal timer runs and then sets the gate bit by hardware. Neither bit reads back as 0 at once after a clear. A settle counter keeps the readback at 1 for a fixed number of clocks, and software polls until the bit reads 0.

The usual bring-up sequence has four steps:
1. Clear the soft-reset bit and poll until it reads 0.
2. Clear the gate bit, then set the soft-reset bit.
3. Poll until the gate bit reads 1.
4. Clear both bits in turn, polling each one.

Top module: `softrst_ctrl`

## Requirements
- R1: On power-on reset (`rst` high), both bits read 1. `rd_data` is 0xC000_0000, `blk_rst_o` is 1 and `blk_clk_en_o` is 0.
- R2: Writes are decoded from word offset `wr_addr[3:2]`. Offset 0 (byte 0x0) is a plain write, 1 (0x4) is set-only, 2 (0x8) is clear-only. A write to offset 3 (0xC) has no effect.
- R3: Only write-data bits 31 (soft reset) and 30 (clock gate) are stored. Bits 29..0 of `rd_data` always read 0.
- R4: A bit that a write sets (plain write with the bit at 1, or set alias with the bit at 1) reads 1 from the first cycle after the write edge.
- R5: After the soft-reset bit is cleared, it reads 1 for SETTLE_CLKS cycles after the write edge (default 3) and reads 0 from the SETTLE_CLKS-th edge on. A new set request during that time keeps it at 1.
- R6: After the clock-gate bit is cleared, it follows the same settle delay of SETTLE_CLKS cycles before it reads 0.
- R7: While the soft-reset bit reads 1 and the gate bit is not requested, the gate bit is set by hardware on the GATE_DELAY-th clock edge after the soft-reset readback rose (default 4). If software clears the gate bit while reset is held, the hardware sets it again by the same rule.
- R8: `blk_rst_o` equals the soft-reset readback. It rises only after a write that sets bit 31.
- R9: `blk_clk_en_o` is the inverse of the clock-gate readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the controlled unit |
| rst | input | 1 | Power-on reset, synchronous, active high |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address within the alias window |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current readback word (bits 31, 30; others 0) |
| blk_rst_o | output | 1 | Synchronous reset to the protected logic |
| blk_clk_en_o | output | 1 | Clock-enable to the protected logic |

## Verification
The bench builds the block with GATE_DELAY=4 and SETTLE_CLKS=3. With these small windows, a full reset, gate, release and ungate sequence runs in a few dozen cycles, so the bench can sample the exact cycle where each bit flips. Because GATE_DELAY is larger than SETTLE_CLKS, a clear of both bits together ends with the gate bit at 0. The settling soft-reset bit does not trigger the hardware set first, and the bench checks this case. The same sizes let the bench clear the gate bit while reset is held and see it set again on the fourth edge.

// File: rtl/softrst_pkg.sv
package softrst_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned SRST_POS = 31;
    localparam int unsigned GATE_POS = 30;

    typedef enum logic [1:0] {
        WK_PLAIN = 2'd0,
        WK_SET   = 2'd1,
        WK_CLEAR = 2'd2,
        WK_NONE  = 2'd3
    } wr_kind_e;

    typedef struct packed {
        logic srst;
        logic gate;
    } ctl_bits_t;

    function automatic wr_kind_e kind_of(input logic [1:0] word);
        case (word)
            2'd0:    return WK_PLAIN;
            2'd1:    return WK_SET;
            2'd2:    return WK_CLEAR;
            default: return WK_NONE;
        endcase
    endfunction

    function automatic logic next_bit(input wr_kind_e k, input logic cur, input logic d);
        case (k)
            WK_PLAIN: return d;
            WK_SET:   return cur | d;
            WK_CLEAR: return cur & ~d;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/softrst_wr_decode.sv
module softrst_wr_decode
    import softrst_pkg::*;
(
    input  logic       wr_en,
    input  logic [1:0] word,
    input  logic       d_srst,
    input  logic       d_gate,
    input  ctl_bits_t  cur,
    output ctl_bits_t  nxt
);
    wr_kind_e kind;

    always_comb begin
        kind = wr_en ? kind_of(word) : WK_NONE;
        nxt.srst = next_bit(kind, cur.srst, d_srst);
        nxt.gate = next_bit(kind, cur.gate, d_gate);
    end
endmodule

// File: rtl/softrst_settle.sv
module softrst_settle #(
    parameter int unsigned SETTLE_CLKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic rd
);
    localparam int unsigned CW = $clog2(SETTLE_CLKS + 1);
    localparam logic [CW-1:0] FULL = CW'(SETTLE_CLKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= FULL;
        end else if (req) begin
            cnt_q <= FULL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign rd = req | (cnt_q != '0);
endmodule

// File: rtl/softrst_gate_timer.sv
module softrst_gate_timer #(
    parameter int unsigned GATE_DELAY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic srst_rd,
    input  logic gate_req,
    output logic fire
);
    localparam int unsigned DW = $clog2(GATE_DELAY + 1);
    localparam logic [DW-1:0] LAST = DW'(GATE_DELAY - 1);

    logic [DW-1:0] cnt_q;
    logic          armed;

    assign armed = srst_rd & ~gate_req;
    assign fire  = armed & (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (armed && !fire) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end
endmodule

// File: rtl/softrst_ctrl.sv
module softrst_ctrl
    import softrst_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned GATE_DELAY  = 4,
    parameter int unsigned SETTLE_CLKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              blk_rst_o,
    output logic              blk_clk_en_o
);
    localparam int unsigned NBITS = $bits(ctl_bits_t);

    ctl_bits_t        req_q;
    ctl_bits_t        req_wr;
    ctl_bits_t        req_d;
    ctl_bits_t        rd_bits;
    logic [NBITS-1:0] req_v;
    logic [NBITS-1:0] rd_v;
    logic             gate_fire;

    logic [ADDR_W-1:0] addr_unused;
    logic [DATA_W-1:0] wdata_unused;
    assign addr_unused  = wr_addr;
    assign wdata_unused = wr_data;

    softrst_wr_decode u_dec (
        .wr_en  (wr_en),
        .word   (wr_addr[3:2]),
        .d_srst (wr_data[SRST_POS]),
        .d_gate (wr_data[GATE_POS]),
        .cur    (req_q),
        .nxt    (req_wr)
    );

    always_comb begin
        req_d = req_wr;
        if (gate_fire) begin
            req_d.gate = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '{srst: 1'b1, gate: 1'b1};
        end else begin
            req_q <= req_d;
        end
    end

    assign req_v = req_q;

    for (genvar i = 0; i < NBITS; i++) begin : g_settle
        softrst_settle #(.SETTLE_CLKS(SETTLE_CLKS)) u_settle (
            .clk (clk),
            .rst (rst),
            .req (req_v[i]),
            .rd  (rd_v[i])
        );
    end

    assign rd_bits = ctl_bits_t'(rd_v);

    softrst_gate_timer #(.GATE_DELAY(GATE_DELAY)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .srst_rd  (rd_bits.srst),
        .gate_req (req_q.gate),
        .fire     (gate_fire)
    );

    always_comb begin
        rd_data           = '0;
        rd_data[SRST_POS] = rd_bits.srst;
        rd_data[GATE_POS] = rd_bits.gate;
    end

    assign blk_rst_o    = rd_bits.srst;
    assign blk_clk_en_o = ~rd_bits.gate;
endmodule

// File: rtl/softrst_ctrl_chk.sv
module softrst_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [1:0] wr_word,
    input logic [1:0] wd_hi,
    input logic [1:0] rd_hi,
    input logic       blk_rst_o,
    input logic       blk_clk_en_o
);
    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (rd_hi == 2'b11 && blk_rst_o && !blk_clk_en_o));

    // R2
    a_r2_reserved_noop: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_word == 2'd3 && rd_hi == 2'b00) |=> (rd_hi == 2'b00));

    // R4
    a_r4_set_alias_rises: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_word == 2'd1 && wd_hi[1]) |=> rd_hi[1]);

    // R4
    a_r4_plain_gate_rises: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_word == 2'd0 && wd_hi[0]) |=> rd_hi[0]);

    // R5
    a_r5_srst_clear_lags: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_word == 2'd2 && wd_hi[1] && rd_hi[1]) |=> rd_hi[1]);

    // R6
    a_r6_gate_clear_lags: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_word == 2'd2 && wd_hi[0] && rd_hi[0]) |=> rd_hi[0]);

    // R8
    a_r8_rise_needs_write: assert property (@(posedge clk) disable iff (rst)
        $rose(blk_rst_o) |-> $past(wr_en && (wr_word == 2'd0 || wr_word == 2'd1) && wd_hi[1]));
endmodule

bind softrst_ctrl softrst_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_word      (wr_addr[3:2]),
    .wd_hi        (wr_data[31:30]),
    .rd_hi        (rd_data[31:30]),
    .blk_rst_o    (blk_rst_o),
    .blk_clk_en_o (blk_clk_en_o)
);

// File: tb/softrst_ctrl_test.sv
`timescale 1ns/1ps
module softrst_ctrl_test;
    localparam int ADDR_W = 4;
    localparam int OP_PLAIN = 0, OP_SET = 1, OP_CLR = 2, OP_RSVD = 3, OP_IDLE = 4;

    // entry: op[40:38] data[37:6] n[5:2] exp{srst,gate}[1:0]
    localparam int NV = 12;
    localparam logic [40:0] VEC [NV] = '{
        {3'd2, 32'h8000_0000, 4'd2, 2'b11},  // R5 still settling
        {3'd4, 32'h0000_0000, 4'd0, 2'b01},  // R5 now 0
        {3'd2, 32'h4000_0000, 4'd2, 2'b01},  // R6 settling
        {3'd4, 32'h0000_0000, 4'd0, 2'b00},  // R6 now 0
        {3'd1, 32'h8000_0000, 4'd3, 2'b10},  // R4 R7 gate not yet set
        {3'd4, 32'h0000_0000, 4'd0, 2'b11},  // R7 gate set by hardware
        {3'd2, 32'h8000_0000, 4'd2, 2'b11},  // R5
        {3'd4, 32'h0000_0000, 4'd0, 2'b01},  // R5
        {3'd0, 32'h0000_0000, 4'd2, 2'b01},  // R6 plain write
        {3'd4, 32'h0000_0000, 4'd0, 2'b00},  // R6
        {3'd1, 32'h4000_0000, 4'd0, 2'b01},  // R4 set alias, gate only
        {3'd0, 32'hC000_0000, 4'd0, 2'b11}   // R4 plain write sets both
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [31:0]       rd_data;
    logic              blk_rst_o;
    logic              blk_clk_en_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    softrst_ctrl #(.ADDR_W(ADDR_W), .GATE_DELAY(4), .SETTLE_CLKS(3)) uut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .blk_rst_o    (blk_rst_o),
        .blk_clk_en_o (blk_clk_en_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input logic [1:0] e);
        chk(req, rd_data, {e, 30'b0});
        chk("R8", {31'b0, blk_rst_o}, {31'b0, e[1]});
        chk("R9", {31'b0, blk_clk_en_o}, {31'b0, ~e[0]});
    endtask

    task automatic step(input int op, input logic [31:0] data, input int n);
        @(negedge clk);
        if (op != OP_IDLE) begin
            wr_en   = 1'b1;
            wr_addr = ADDR_W'(op * 4);
            wr_data = data;
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk_state("R1", 2'b11);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(int'(VEC[i][40:38]), VEC[i][37:6], int'(VEC[i][5:2]));
            chk_state("R4 R5 R6 R7 table", VEC[i][1:0]);
        end

        // R2: reserved offset changes nothing
        step(OP_RSVD, 32'h0000_0000, 4);
        chk_state("R2", 2'b11);

        // R3: low bits ignored, settle on both, no hardware gate set
        step(OP_PLAIN, 32'h3FFF_FFFF, 0);
        chk_state("R3", 2'b11);
        step(OP_IDLE, 32'h0, 1);
        chk_state("R5", 2'b11);
        step(OP_IDLE, 32'h0, 3);
        chk_state("R3", 2'b00);

        // R7: gate cleared while reset is held comes back
        step(OP_PLAIN, 32'hC000_0000, 0);
        chk_state("R4", 2'b11);
        step(OP_CLR, 32'h4000_0000, 3);
        chk_state("R7", 2'b10);
        step(OP_IDLE, 32'h0, 0);
        chk_state("R7", 2'b11);

        // R5: new set during settle keeps reset at 1
        step(OP_CLR, 32'h8000_0000, 1);
        chk_state("R5", 2'b11);
        step(OP_SET, 32'h8000_0000, 3);
        chk_state("R5", 2'b11);

        // R1: mid-run power-on reset
        step(OP_PLAIN, 32'h0000_0000, 5);
        chk_state("R6", 2'b00);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk_state("R1", 2'b11);
        @(negedge clk);
        rst = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule